// File: doc/BRIEF.md
# Hashed Filter Table Search Engine

This block keeps an open-addressed table of filter entries in an on-chip RAM and serves insert, lookup, delete and clear-all commands one at a time. Every entry is made of a 3-bit filter type, a 32-bit n-tuple key and a queue id. The key is hashed to a starting slot. A collision is resolved by stepping through the table with an odd stride taken from the key, so the whole table is visited before any slot repeats. A flop bitmap records which slots are occupied, and a counter tracks how many are in use.

For each of the eight filter types the engine records the deepest probe that any successful insert needed. From that record it exports a search limit, which the downstream matching hardware uses to bound its own walk. The engine examines one slot per clock over a RAM with one-cycle read latency. Each response reports a status, the slot index, and the probe depth at which the search ended.

Commands enter on a valid/ready channel. `cmd_ready` is high only while the engine is idle, so exactly one command is in flight. A response is presented on `rsp_valid` and held unchanged, with all its fields stable, until the consumer asserts `rsp_ready`. A new command is accepted only after that response has been taken. Stalling the response channel therefore stalls the command channel.

Top module: `fht_engine`

## Requirements
- R1: The start slot is the low SLOT_AW bits of a 16-bit hash of the key. The hash works as follows: t = 0x1fff ^ key[31:16]; t ^= (t>>3)^(t>>6); t ^= t>>9; t = t ^ (t<<13) ^ key[15:0]; t ^= (t>>3)^(t>>6); t ^= t>>9. All arithmetic is truncated to 16 bits.
- R2: Each later slot is (previous slot + stride) modulo the table size, where stride = (2*key - 1) truncated to 16 bits.
- R3: A probe succeeds on an occupied slot whose entry equals the request, or on a free slot when the command is an insert. The first slot probed has depth 1, and the response carries the slot index and the depth at which the probe succeeded, with status OK (0).
- R4: If no probe succeeds by depth MAX_DEPTH (200), the response has depth MAX_DEPTH. An insert (opcode 0) returns BUSY (2). A lookup (opcode 1) or delete (opcode 2) returns NOTFOUND (3).
- R5: An insert whose probe succeeds on an occupied, equal slot returns EXISTS (1) and changes nothing, unless `cmd_replace` is set. With `cmd_replace` set, the entry is rewritten and the response is OK at the same slot.
- R6: Two entries are equal when their types and keys match. For transmit types (type bit 2 = 1) the queue ids must match as well. For receive types the queue id is ignored.
- R7: A successful insert raises the recorded maximum for its type to the probe depth if that depth is larger. `search_limit[t*DEPTH_W +: DEPTH_W]` equals the maximum for type t plus FULL_OFS (1) for full-match types (type bit 0 = 0), or plus WILD_OFS (3) for wildcard types (type bit 0 = 1).
- R8: A successful delete frees its slot, so later lookups of that entry miss. When the used count drops to zero, every recorded maximum returns to 0.
- R9: Clear-all (opcode 3) zeroes every slot and empties the bitmap, the used count and all maxima. It responds OK with slot 0 and depth 0.
- R10: `cmd_ready` is low from acceptance until the response is taken. While `rsp_valid` is high and `rsp_ready` is low, all response fields hold steady.
- R11: After reset, `cmd_ready` is 1, `rsp_valid` is 0, and each search limit equals its type's offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_op | input | 2 | 0 insert, 1 lookup, 2 delete, 3 clear-all |
| cmd_key | input | 32 | N-tuple key |
| cmd_type | input | 3 | Filter type; bit 2 transmit, bit 0 wildcard |
| cmd_qid | input | QID_W (8) | Queue id of the entry |
| cmd_replace | input | 1 | Permit overwriting an equal entry on insert |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes response |
| rsp_status | output | 2 | 0 OK, 1 EXISTS, 2 BUSY, 3 NOTFOUND |
| rsp_slot | output | SLOT_AW | Slot where the search ended |
| rsp_depth | output | DEPTH_W | Probe depth at the end of the search |
| search_limit | output | 8*DEPTH_W | Per-type search limits, type t at bits t*DEPTH_W |

## Verification
A bitmap bit set without its entry in the RAM, or a used count that disagrees with the bitmap, corrupts the very next probe that touches that slot. It also corrupts the depth reset on the delete that should empty the table. The bench therefore follows each insert with lookups and deletes, and compares slot, depth and status against a model at every response. A wrong recorded maximum shows up on `search_limit` one cycle after the insert's response, and it is checked there. A stride or hash error moves the reported slot on the first collision, which the bench forces on purpose.

// File: rtl/fht_pkg.sv
package fht_pkg;
  localparam int TYPE_W = 3;
  localparam int NTYPES = 1 << TYPE_W;
  localparam int QID_W  = 8;
  localparam int KEY_W  = 32;

  typedef enum logic [1:0] {
    OP_INSERT = 2'd0,
    OP_LOOKUP = 2'd1,
    OP_DELETE = 2'd2,
    OP_CLEAR  = 2'd3
  } op_t;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_EXISTS   = 2'd1,
    ST_BUSY     = 2'd2,
    ST_NOTFOUND = 2'd3
  } status_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_PROBE,
    S_WIPE,
    S_RESP
  } fsm_t;

  typedef struct packed {
    logic [TYPE_W-1:0] ftype;
    logic [KEY_W-1:0]  key;
    logic [QID_W-1:0]  qid;
  } entry_t;
endpackage

// File: rtl/fht_hash.sv
module fht_hash #(
  parameter int AW = 6
) (
  input  logic [31:0]   key_i,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] stride_o
);
  logic [15:0] h0, h1, h2, h3, h4, h5;
  logic [15:0] step;

  always_comb begin
    h0 = 16'h1fff ^ key_i[31:16];
    h1 = h0 ^ (h0 >> 3) ^ (h0 >> 6);
    h2 = h1 ^ (h1 >> 9);
    h3 = h2 ^ (h2 << 13) ^ key_i[15:0];
    h4 = h3 ^ (h3 >> 3) ^ (h3 >> 6);
    h5 = h4 ^ (h4 >> 9);
    step = {key_i[14:0], 1'b0} - 16'd1;
  end

  assign start_o  = h5[AW-1:0];
  assign stride_o = step[AW-1:0];
endmodule

// File: rtl/fht_ram.sv
module fht_ram #(
  parameter int AW = 6,
  parameter int W  = 43
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [1<<AW];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else    rdata     <= mem[addr];
  end
endmodule

// File: rtl/fht_limits.sv
module fht_limits #(
  parameter int NT       = 8,
  parameter int DW       = 8,
  parameter int FULL_OFS = 1,
  parameter int WILD_OFS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  raise_en,
  input  logic [$clog2(NT)-1:0] raise_type,
  input  logic [DW-1:0]         raise_depth,
  input  logic                  wipe,
  output logic [NT*DW-1:0]      limit_o
);
  for (genvar t = 0; t < NT; t++) begin : g_type
    localparam logic [DW-1:0] OFS = DW'((t % 2 == 1) ? WILD_OFS : FULL_OFS);
    logic [DW-1:0] max_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        max_q <= '0;
      end else if (wipe) begin
        max_q <= '0;
      end else if (raise_en && raise_type == t[$clog2(NT)-1:0] && raise_depth > max_q) begin
        max_q <= raise_depth;
      end
    end

    assign limit_o[t*DW +: DW] = max_q + OFS;
  end
endmodule

// File: rtl/fht_engine.sv
module fht_engine
  import fht_pkg::*;
#(
  parameter int SLOT_AW   = 6,
  parameter int MAX_DEPTH = 200,
  parameter int FULL_OFS  = 1,
  parameter int WILD_OFS  = 3,
  localparam int SLOTS    = 1 << SLOT_AW,
  localparam int DEPTH_W  = $clog2(MAX_DEPTH + WILD_OFS + 1),
  localparam int ENT_W    = $bits(entry_t)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [1:0]                cmd_op,
  input  logic [KEY_W-1:0]          cmd_key,
  input  logic [TYPE_W-1:0]         cmd_type,
  input  logic [QID_W-1:0]          cmd_qid,
  input  logic                      cmd_replace,
  output logic                      rsp_valid,
  input  logic                      rsp_ready,
  output logic [1:0]                rsp_status,
  output logic [SLOT_AW-1:0]        rsp_slot,
  output logic [DEPTH_W-1:0]        rsp_depth,
  output logic [NTYPES*DEPTH_W-1:0] search_limit
);
  localparam logic [DEPTH_W-1:0] CAP = DEPTH_W'(MAX_DEPTH);

  fsm_t               st;
  op_t                op_q;
  entry_t             ent_q;
  logic               rep_q;
  logic [SLOT_AW-1:0] stride_q, slot_q, wipe_q;
  logic [DEPTH_W-1:0] depth_q;
  logic [SLOTS-1:0]   occ;
  logic [SLOT_AW:0]   used_q;
  status_t            stat_q;

  logic [SLOT_AW-1:0] h_start, h_stride, next_slot;
  logic               ram_we;
  logic [SLOT_AW-1:0] ram_addr;
  logic [ENT_W-1:0]   ram_wdata, ram_rdata;
  entry_t             rd_ent;
  logic               accept, cur_occ, same, hit, at_cap, ins_write;
  logic               raise_en, wipe_depths;

  fht_hash #(.AW(SLOT_AW)) u_hash (
    .key_i(cmd_key), .start_o(h_start), .stride_o(h_stride)
  );

  fht_ram #(.AW(SLOT_AW), .W(ENT_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
  );

  fht_limits #(.NT(NTYPES), .DW(DEPTH_W), .FULL_OFS(FULL_OFS), .WILD_OFS(WILD_OFS)) u_lim (
    .clk(clk), .rst_n(rst_n), .raise_en(raise_en), .raise_type(ent_q.ftype),
    .raise_depth(depth_q), .wipe(wipe_depths), .limit_o(search_limit)
  );

  assign cmd_ready = (st == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign rd_ent    = entry_t'(ram_rdata);
  assign cur_occ   = occ[slot_q];
  assign same      = (rd_ent.ftype == ent_q.ftype) && (rd_ent.key == ent_q.key) &&
                     (!ent_q.ftype[TYPE_W-1] || rd_ent.qid == ent_q.qid);
  assign hit       = cur_occ ? same : (op_q == OP_INSERT);
  assign at_cap    = (depth_q == CAP);
  assign next_slot = slot_q + stride_q;
  assign ins_write = (op_q == OP_INSERT) && (!cur_occ || rep_q);

  assign raise_en    = (st == S_PROBE) && hit && ins_write;
  assign wipe_depths = (accept && op_t'(cmd_op) == OP_CLEAR) ||
                       ((st == S_PROBE) && hit && op_q == OP_DELETE && used_q == 1);

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = slot_q;
    ram_wdata = '0;
    unique case (st)
      S_IDLE:  ram_addr = h_start;
      S_PROBE: begin
        if (hit) begin
          if (ins_write) begin
            ram_we    = 1'b1;
            ram_wdata = ent_q;
          end else if (op_q == OP_DELETE) begin
            ram_we = 1'b1;
          end
        end else begin
          ram_addr = next_slot;
        end
      end
      S_WIPE: begin
        ram_we   = 1'b1;
        ram_addr = wipe_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      op_q     <= OP_LOOKUP;
      ent_q    <= '0;
      rep_q    <= 1'b0;
      stride_q <= '0;
      slot_q   <= '0;
      wipe_q   <= '0;
      depth_q  <= '0;
      occ      <= '0;
      used_q   <= '0;
      stat_q   <= ST_OK;
    end else begin
      unique case (st)
        S_IDLE: if (accept) begin
          op_q     <= op_t'(cmd_op);
          ent_q    <= '{ftype: cmd_type, key: cmd_key, qid: cmd_qid};
          rep_q    <= cmd_replace;
          stride_q <= h_stride;
          slot_q   <= h_start;
          depth_q  <= DEPTH_W'(1);
          if (op_t'(cmd_op) == OP_CLEAR) begin
            occ     <= '0;
            used_q  <= '0;
            wipe_q  <= '0;
            slot_q  <= '0;
            depth_q <= '0;
            st      <= S_WIPE;
          end else begin
            st <= S_PROBE;
          end
        end
        S_PROBE: begin
          if (hit) begin
            st <= S_RESP;
            unique case (op_q)
              OP_INSERT: begin
                if (ins_write) begin
                  stat_q       <= ST_OK;
                  occ[slot_q]  <= 1'b1;
                  if (!cur_occ) used_q <= used_q + 1'b1;
                end else begin
                  stat_q <= ST_EXISTS;
                end
              end
              OP_DELETE: begin
                stat_q      <= ST_OK;
                occ[slot_q] <= 1'b0;
                used_q      <= used_q - 1'b1;
              end
              default: stat_q <= ST_OK;
            endcase
          end else if (at_cap) begin
            st     <= S_RESP;
            stat_q <= (op_q == OP_INSERT) ? ST_BUSY : ST_NOTFOUND;
          end else begin
            slot_q  <= next_slot;
            depth_q <= depth_q + 1'b1;
          end
        end
        S_WIPE: begin
          wipe_q <= wipe_q + 1'b1;
          if (wipe_q == SLOT_AW'(SLOTS - 1)) begin
            stat_q <= ST_OK;
            st     <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rsp_valid  = (st == S_RESP);
  assign rsp_status = stat_q;
  assign rsp_slot   = slot_q;
  assign rsp_depth  = depth_q;
endmodule

// File: rtl/fht_checker.sv
module fht_checker #(
  parameter int SLOT_AW   = 6,
  parameter int MAX_DEPTH = 200,
  parameter int DEPTH_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [1:0]         rsp_status,
  input logic [SLOT_AW-1:0] rsp_slot,
  input logic [DEPTH_W-1:0] rsp_depth,
  input logic [SLOT_AW:0]   used_cnt,
  input logic [(1<<SLOT_AW)-1:0] occ_map
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_status) && $stable(rsp_slot) && $stable(rsp_depth)); // R10
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready); // R10
  AST_DEPTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_depth <= DEPTH_W'(MAX_DEPTH)); // R4
  AST_GIVEUP_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status[1] |-> rsp_depth == DEPTH_W'(MAX_DEPTH)); // R4
  AST_EXISTS_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_status == 2'd1 |-> rsp_depth != 0); // R5
  AST_OCC_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ_map) == int'(used_cnt)); // R8
endmodule

bind fht_engine fht_checker #(.SLOT_AW(SLOT_AW), .MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_slot(rsp_slot),
  .rsp_depth(rsp_depth), .used_cnt(used_q), .occ_map(occ)
);

// File: tb/sim_fht_engine.sv
module sim_fht_engine;
  localparam int AW = 6;
  localparam int NS = 1 << AW;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_replace = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [31:0] cmd_key = '0;
  logic [2:0] cmd_type = '0;
  logic [7:0] cmd_qid = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [1:0] rsp_status;
  logic [AW-1:0] rsp_slot;
  logic [DW-1:0] rsp_depth;
  logic [8*DW-1:0] search_limit;

  always #2 clk = ~clk;

  fht_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_key(cmd_key), .cmd_type(cmd_type), .cmd_qid(cmd_qid),
    .cmd_replace(cmd_replace), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_slot(rsp_slot), .rsp_depth(rsp_depth),
    .search_limit(search_limit)
  );

  int checks = 0, errors = 0;
  bit mo[NS]; int unsigned mk[NS]; int mt[NS]; int mq[NS];
  int mused = 0; int mmax[8];
  int e_st, e_slot, e_dep;
  int r_st, r_slot, r_dep;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bhash(logic [31:0] k);
    logic [15:0] t;
    t = 16'h1fff ^ k[31:16];
    t = t ^ (t >> 3) ^ (t >> 6);
    t = t ^ (t >> 9);
    t = t ^ (t << 13) ^ k[15:0];
    t = t ^ (t >> 3) ^ (t >> 6);
    t = t ^ (t >> 9);
    return t;
  endfunction

  function automatic int start_of(logic [31:0] k);
    return int'(bhash(k)) & (NS - 1);
  endfunction

  // model of R1..R9
  task automatic model(int op, logic [31:0] k, int ty, int q, bit rep);
    int s, sd;
    bit m;
    if (op == 3) begin
      for (int i = 0; i < NS; i++) mo[i] = 0;
      for (int i = 0; i < 8; i++) mmax[i] = 0;
      mused = 0; e_st = 0; e_slot = 0; e_dep = 0;
      return;
    end
    s = start_of(k);
    sd = int'(k * 2 - 1) & (NS - 1);
    for (int d = 1; d <= 200; d++) begin
      m = mo[s] ? (mt[s] == ty && mk[s] == k && (ty < 4 || mq[s] == q)) : (op == 0);
      if (m) begin
        e_slot = s; e_dep = d; e_st = 0;
        if (op == 0) begin
          if (mo[s] && !rep) e_st = 1;
          else begin
            if (!mo[s]) mused++;
            mo[s] = 1; mk[s] = k; mt[s] = ty; mq[s] = q;
            if (d > mmax[ty]) mmax[ty] = d;
          end
        end else if (op == 2) begin
          mo[s] = 0; mused--;
          if (mused == 0) for (int i = 0; i < 8; i++) mmax[i] = 0;
        end
        return;
      end
      if (d == 200) begin
        e_slot = s; e_dep = 200; e_st = (op == 0) ? 2 : 3;
        return;
      end
      s = (s + sd) & (NS - 1);
    end
  endtask

  task automatic issue(int op, logic [31:0] k, int ty, int q, bit rep);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op[1:0]; cmd_key = k; cmd_type = ty[2:0];
    cmd_qid = q[7:0]; cmd_replace = rep;
    @(negedge clk);
    cmd_valid = 0;
    while (!rsp_valid) @(negedge clk);
    r_st = rsp_status; r_slot = rsp_slot; r_dep = rsp_depth;
  endtask

  task automatic take;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic run(string req, int op, logic [31:0] k, int ty, int q, bit rep);
    issue(op, k, ty, q, rep);
    take();
    model(op, k, ty, q, rep);
    chk({req, " status"}, r_st, e_st);
    if (e_st < 2) chk({req, " slot"}, r_slot, e_slot);
    chk({req, " depth"}, r_dep, e_dep);
  endtask

  task automatic check_limits(string req);
    for (int t = 0; t < 8; t++)
      chk(req, int'(search_limit[t*DW +: DW]), mmax[t] + ((t % 2) ? 3 : 1));
  endtask

  logic [31:0] ka = 32'h0001_0203, kb, kc, kd = 32'h7777_1234;

  function automatic logic [31:0] find_collider(logic [31:0] ref_k, logic [31:0] base);
    for (int i = 0; i < 20000; i++)
      if (start_of(base + i) == start_of(ref_k) && (base + i) != ref_k) return base + i;
    return base;
  endfunction

  task automatic t_reset;
    chk("R11 cmd_ready", cmd_ready, 1);
    chk("R11 rsp_valid", rsp_valid, 0);
    check_limits("R11 limits");
  endtask

  task automatic t_basic;
    run("R1 insert rx", 0, ka, 0, 0, 0);
    chk("R3 first depth", r_dep, 1);
    run("R1 insert tx", 0, kd, 4, 5, 0);
    run("R3 lookup", 1, ka, 0, 0, 0);
    run("R4 lookup absent", 1, 32'hDEAD_BEEF, 2, 0, 0);
  endtask

  task automatic t_collide;
    kb = find_collider(ka, 32'h0100_0000);
    kc = find_collider(ka, 32'h0200_0000);
    chk("R1 collider found", start_of(kb), start_of(ka));
    run("R2 collide insert", 0, kb, 0, 1, 0);
    chk("R2 second probe", r_dep, 2);
    run("R2 collide wild", 0, kc, 1, 2, 0);
    @(negedge clk);
    check_limits("R7 raised");
  endtask

  task automatic t_dup;
    run("R5 dup", 0, ka, 0, 0, 0);
    chk("R5 exists", r_st, 1);
    run("R5 replace", 0, ka, 0, 0, 1);
    chk("R5 replace ok", r_st, 0);
  endtask

  task automatic t_equal;
    run("R6 tx qid mismatch", 1, kd, 4, 6, 0);
    chk("R6 tx miss", r_st, 3);
    run("R6 tx qid match", 1, kd, 4, 5, 0);
    run("R6 rx qid ignored", 1, ka, 0, 9, 0);
    chk("R6 rx hit", r_st, 0);
  endtask

  task automatic t_backpressure;
    int s0, l0, d0;
    issue(1, kb, 0, 1, 0);
    s0 = r_st; l0 = r_slot; d0 = r_dep;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 held valid", rsp_valid, 1);
      chk("R10 ready low", cmd_ready, 0);
      chk("R10 stable slot", rsp_slot, l0);
      chk("R10 stable depth", rsp_depth, d0);
    end
    take();
    model(1, kb, 0, 1, 0);
    chk("R10 status", s0, e_st);
    chk("R10 slot", l0, e_slot);
    chk("R10 back idle", cmd_ready, 1);
  endtask

  task automatic t_delete;
    run("R8 delete", 2, kb, 0, 1, 0);
    run("R8 lookup gone", 1, kb, 0, 1, 0);
    chk("R8 gone", r_st, 3);
    run("R8 other kept", 1, kc, 1, 2, 0);
    run("R8 del a", 2, ka, 0, 0, 0);
    run("R8 del c", 2, kc, 1, 2, 0);
    run("R8 del d", 2, kd, 4, 5, 0);
    run("R8 del absent", 2, kd, 4, 5, 0);
    @(negedge clk);
    check_limits("R8 depths reset");
  endtask

  task automatic t_full_clear;
    for (int i = 0; i < NS; i++) run("R3 fill", 0, 32'hA000_0000 + i * 7919, 5, i, 0);
    run("R4 busy", 0, 32'h5555_0001, 5, 0, 0);
    chk("R4 busy code", r_st, 2);
    run("R4 full miss", 1, 32'h5555_0001, 5, 0, 0);
    @(negedge clk);
    check_limits("R7 full limits");
    run("R9 clear", 3, 0, 0, 0, 0);
    @(negedge clk);
    check_limits("R9 limits");
    run("R9 lookup after", 1, 32'hA000_0000, 5, 0, 0);
    chk("R9 miss", r_st, 3);
    run("R9 reinsert", 0, 32'hA000_0000, 5, 0, 0);
    chk("R9 depth one", r_dep, 1);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mmax[i] = 0;
    for (int i = 0; i < NS; i++) mo[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_collide();
    t_dup();
    t_equal();
    t_backpressure();
    t_delete();
    t_full_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule